// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

A purely combinational datapath slice for an 8-bit processor core. One cycle's worth of logic takes an operand byte, the accumulator, the current flag byte, a bit index and an operation code. It returns the rewritten operand byte, the new accumulator and the new flag byte. Three groups of operations share it. The first is the full rotate and shift family, which acts on the operand byte and sets every flag from the result. The second covers single-bit test, clear and set. The third holds the light accumulator rotates, which keep sign, zero and parity, and the two nibble rotates that move four-bit halves between the accumulator and a memory byte.

The surrounding sequencer fetches the memory byte, presents it on `opnd_i` and writes `result_o` back where the operation calls for it. This unit holds no state and has no clock. Data width, the bit positions copied into the two spare flags and the placement of every flag inside the flag byte are parameters. The defaults give the layout written below.

Top module: `rsb_unit`

## Requirements
- R1: Operation codes (5 bits): 0 rotate-left-circular, 1 rotate-right-circular, 2 rotate-left-through-carry, 3 rotate-right-through-carry, 4 shift-left inserting 0, 5 arithmetic shift right, 6 shift-left inserting 1, 7 logical shift right, 8 bit test, 9 bit clear, 10 bit set, 12..15 accumulator rotates (same order as 0..3), 16 nibble rotate left, 17 nibble rotate right. Any other code (11, 18..31) passes all three inputs through: `result_o`=`opnd_i`, `acc_o`=`acc_i`, `flags_o`=`flags_i`.
- R2: Codes 0 and 1 rotate `opnd_i` by one place. The bit that leaves (bit 7 for left, bit 0 for right) enters the opposite end and also goes to carry.
- R3: Codes 2 and 3 rotate `opnd_i` through carry. The old carry enters bit 0 (left) or bit 7 (right), and the bit that leaves goes to carry.
- R4: Code 4 shifts left and inserts 0. Code 6 shifts left and inserts 1. Code 5 shifts right and keeps bit 7. Code 7 shifts right and inserts 0. In each case the bit shifted out goes to carry.
- R5: The flag byte layout is bit 7 sign, bit 6 zero, bit 5 copy of result bit 5, bit 4 half-carry, bit 3 copy of result bit 3, bit 2 parity (1 when the count of ones is even), bit 1 add/subtract and bit 0 carry. For codes 0..7, sign, zero, parity and both copies come from `result_o`, while half-carry and add/subtract are 0. `acc_o` equals `acc_i`.
- R6: Code 8 sets zero exactly when bit `bit_sel_i` of `opnd_i` is 0, sets half-carry to 1 and clears add/subtract. The other five flags are unchanged, and `result_o`=`opnd_i`.
- R7: Code 9 clears and code 10 sets bit `bit_sel_i` of `opnd_i` on `result_o`, leaving the other bits alone. `flags_o` equals `flags_i`.
- R8: Codes 12..15 rotate `acc_i` into `acc_o` with the same bit movement as codes 0..3. Only carry, half-carry (0), add/subtract (0) and the bit-5/bit-3 copies change. Sign, zero and parity are kept, and `result_o`=`opnd_i`.
- R9: Code 16 gives `result_o` = {`opnd_i`[3:0], `acc_i`[3:0]} and `acc_o` = {`acc_i`[7:4], `opnd_i`[7:4]}.
- R10: Code 17 gives `result_o` = {`acc_i`[3:0], `opnd_i`[7:4]} and `acc_o` = {`acc_i`[7:4], `opnd_i`[3:0]}.
- R11: For codes 16 and 17, sign, zero, parity and both copies come from the new accumulator, half-carry and add/subtract are 0, and carry is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand / memory byte |
| acc_i | input | 8 | Current accumulator |
| flags_i | input | 8 | Current flag byte |
| bit_sel_i | input | 3 | Bit index for test, clear and set |
| op_i | input | 5 | Operation code |
| result_o | output | 8 | Rewritten operand / memory byte |
| acc_o | output | 8 | New accumulator |
| flags_o | output | 8 | New flag byte |

## Verification
The directed sweep takes every one of the 32 codes through the bytes 00, FF, 80, 01, 0F, F0, A5 and 5A with carry both clear and set. These patterns separate the circular, through-carry and inserting variants at both ends of the byte. They also reach the zero and parity extremes and swap distinct nibbles, so the two nibble directions cannot be confused. Random operands, accumulators, flag bytes and bit indices then check that kept flags really come from `flags_i` and not from a constant. They also check that bit test, clear and set hit only the chosen position. Data and flags are compared separately, so a wrong flag is reported against the flag requirement.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_RLC  = 5'd0,
      OP_RRC  = 5'd1,
      OP_RL   = 5'd2,
      OP_RR   = 5'd3,
      OP_SLZ  = 5'd4,
      OP_SRA  = 5'd5,
      OP_SLO  = 5'd6,
      OP_SRL  = 5'd7,
      OP_BTST = 5'd8,
      OP_BCLR = 5'd9,
      OP_BSET = 5'd10,
      OP_ARLC = 5'd12,
      OP_ARRC = 5'd13,
      OP_ARL  = 5'd14,
      OP_ARR  = 5'd15,
      OP_NRL  = 5'd16,
      OP_NRR  = 5'd17
   } rsb_op_e;

   typedef enum logic [1:0] {
      FM_KEEP = 2'd0,
      FM_FULL = 2'd1,
      FM_FAST = 2'd2,
      FM_BTST = 2'd3
   } rsb_fmode_e;

endpackage

// File: rtl/rsb_shift.sv
module rsb_shift #(
   parameter int W = 8
) (
   input  logic [2:0]   kind_i,
   input  logic [W-1:0] data_i,
   input  logic         cin_i,
   output logic [W-1:0] data_o,
   output logic         cout_o
);
   localparam int MSB = W - 1;

   logic left;
   assign left   = ~kind_i[0];
   assign cout_o = left ? data_i[MSB] : data_i[0];

   always_comb begin
      case (kind_i)
         3'd0:    data_o = {data_i[MSB-1:0], data_i[MSB]};
         3'd1:    data_o = {data_i[0], data_i[MSB:1]};
         3'd2:    data_o = {data_i[MSB-1:0], cin_i};
         3'd3:    data_o = {cin_i, data_i[MSB:1]};
         3'd4:    data_o = {data_i[MSB-1:0], 1'b0};
         3'd5:    data_o = {data_i[MSB], data_i[MSB:1]};
         3'd6:    data_o = {data_i[MSB-1:0], 1'b1};
         default: data_o = {1'b0, data_i[MSB:1]};
      endcase
   end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop #(
   parameter int W     = 8,
   parameter int IDX_W = 3
) (
   input  logic [W-1:0]     data_i,
   input  logic [IDX_W-1:0] sel_i,
   output logic [W-1:0]     set_o,
   output logic [W-1:0]     clr_o,
   output logic             zero_o
);
   logic [W-1:0] mask;

   generate
      for (genvar i = 0; i < W; i++) begin : g_mask
         assign mask[i] = (sel_i == IDX_W'(i));
      end
   endgenerate

   assign set_o  = data_i | mask;
   assign clr_o  = data_i & ~mask;
   assign zero_o = ~|(data_i & mask);
endmodule

// File: rtl/rsb_nibble.sv
module rsb_nibble #(
   parameter int W = 8
) (
   input  logic         right_i,
   input  logic [W-1:0] mem_i,
   input  logic [W-1:0] acc_i,
   output logic [W-1:0] mem_o,
   output logic [W-1:0] acc_o
);
   localparam int HALF = W / 2;

   logic [HALF-1:0] m_hi, m_lo, a_hi, a_lo;
   assign m_hi = mem_i[W-1:HALF];
   assign m_lo = mem_i[HALF-1:0];
   assign a_hi = acc_i[W-1:HALF];
   assign a_lo = acc_i[HALF-1:0];

   always_comb begin
      if (right_i) begin
         mem_o = {a_lo, m_hi};
         acc_o = {a_hi, m_lo};
      end else begin
         mem_o = {m_lo, a_lo};
         acc_o = {a_hi, m_hi};
      end
   end
endmodule

// File: rtl/rsb_flags.sv
module rsb_flags
   import rsb_pkg::*;
#(
   parameter int W      = 8,
   parameter int X_SRC  = 3,
   parameter int Y_SRC  = 5,
   parameter int POS_S  = 7,
   parameter int POS_Z  = 6,
   parameter int POS_Y  = 5,
   parameter int POS_H  = 4,
   parameter int POS_X  = 3,
   parameter int POS_P  = 2,
   parameter int POS_N  = 1,
   parameter int POS_C  = 0
) (
   input  rsb_fmode_e   mode_i,
   input  logic [7:0]   flags_i,
   input  logic [W-1:0] val_i,
   input  logic         cout_i,
   input  logic         bzero_i,
   output logic [7:0]   flags_o
);
   always_comb begin
      flags_o = flags_i;
      case (mode_i)
         FM_FULL: begin
            flags_o[POS_S] = val_i[W-1];
            flags_o[POS_Z] = ~|val_i;
            flags_o[POS_P] = ~^val_i;
            flags_o[POS_Y] = val_i[Y_SRC];
            flags_o[POS_X] = val_i[X_SRC];
            flags_o[POS_H] = 1'b0;
            flags_o[POS_N] = 1'b0;
            flags_o[POS_C] = cout_i;
         end
         FM_FAST: begin
            flags_o[POS_Y] = val_i[Y_SRC];
            flags_o[POS_X] = val_i[X_SRC];
            flags_o[POS_H] = 1'b0;
            flags_o[POS_N] = 1'b0;
            flags_o[POS_C] = cout_i;
         end
         FM_BTST: begin
            flags_o[POS_Z] = bzero_i;
            flags_o[POS_H] = 1'b1;
            flags_o[POS_N] = 1'b0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
   import rsb_pkg::*;
#(
   parameter int W      = 8,
   parameter int IDX_W  = $clog2(W),
   parameter int X_SRC  = 3,
   parameter int Y_SRC  = 5,
   parameter int POS_S  = 7,
   parameter int POS_Z  = 6,
   parameter int POS_Y  = 5,
   parameter int POS_H  = 4,
   parameter int POS_X  = 3,
   parameter int POS_P  = 2,
   parameter int POS_N  = 1,
   parameter int POS_C  = 0
) (
   input  logic [W-1:0]     opnd_i,
   input  logic [W-1:0]     acc_i,
   input  logic [7:0]       flags_i,
   input  logic [IDX_W-1:0] bit_sel_i,
   input  logic [OP_W-1:0]  op_i,
   output logic [W-1:0]     result_o,
   output logic [W-1:0]     acc_o,
   output logic [7:0]       flags_o
);
   localparam int FLAG_MASK = (1 << POS_S) | (1 << POS_Z) | (1 << POS_Y) | (1 << POS_H)
                            | (1 << POS_X) | (1 << POS_P) | (1 << POS_N) | (1 << POS_C);

   generate
      if (W < 8 || (W % 2) != 0) begin : g_bad_width
         $error("rsb_unit: W must be even and at least 8");
      end
      if (IDX_W != $clog2(W)) begin : g_bad_idx
         $error("rsb_unit: IDX_W must equal clog2(W)");
      end
      if (X_SRC >= W || Y_SRC >= W || X_SRC < 0 || Y_SRC < 0) begin : g_bad_copy
         $error("rsb_unit: copy sources must lie inside the data word");
      end
      if (FLAG_MASK != 255) begin : g_bad_flags
         $error("rsb_unit: flag positions must be distinct and inside 0..7");
      end
   endgenerate

   // shifter input selection
   logic [2:0]   sh_kind;
   logic [W-1:0] sh_src;
   logic         fast_op;

   assign fast_op = (op_i >= OP_ARLC) && (op_i <= OP_ARR);
   assign sh_src  = fast_op ? acc_i : opnd_i;
   assign sh_kind = fast_op ? {1'b0, op_i[1:0]} : op_i[2:0];

   logic [W-1:0] sh_out;
   logic         sh_cout;

   rsb_shift #(.W(W)) u_shift (
      .kind_i (sh_kind),
      .data_i (sh_src),
      .cin_i  (flags_i[POS_C]),
      .data_o (sh_out),
      .cout_o (sh_cout)
   );

   logic [W-1:0] bit_set, bit_clr;
   logic         bit_zero;

   rsb_bitop #(.W(W), .IDX_W(IDX_W)) u_bitop (
      .data_i (opnd_i),
      .sel_i  (bit_sel_i),
      .set_o  (bit_set),
      .clr_o  (bit_clr),
      .zero_o (bit_zero)
   );

   logic [W-1:0] nib_mem, nib_acc;

   rsb_nibble #(.W(W)) u_nibble (
      .right_i (op_i[0]),
      .mem_i   (opnd_i),
      .acc_i   (acc_i),
      .mem_o   (nib_mem),
      .acc_o   (nib_acc)
   );

   // output selection
   rsb_fmode_e   fmode;
   logic [W-1:0] fval;
   logic         fcout;

   always_comb begin
      result_o = opnd_i;
      acc_o    = acc_i;
      fmode    = FM_KEEP;
      fval     = opnd_i;
      fcout    = flags_i[POS_C];
      case (op_i)
         OP_RLC, OP_RRC, OP_RL, OP_RR,
         OP_SLZ, OP_SRA, OP_SLO, OP_SRL: begin
            result_o = sh_out;
            fval     = sh_out;
            fcout    = sh_cout;
            fmode    = FM_FULL;
         end
         OP_BTST: fmode = FM_BTST;
         OP_BCLR: result_o = bit_clr;
         OP_BSET: result_o = bit_set;
         OP_ARLC, OP_ARRC, OP_ARL, OP_ARR: begin
            acc_o = sh_out;
            fval  = sh_out;
            fcout = sh_cout;
            fmode = FM_FAST;
         end
         OP_NRL, OP_NRR: begin
            result_o = nib_mem;
            acc_o    = nib_acc;
            fval     = nib_acc;
            fmode    = FM_FULL;
         end
         default: ;
      endcase
   end

   rsb_flags #(
      .W(W), .X_SRC(X_SRC), .Y_SRC(Y_SRC),
      .POS_S(POS_S), .POS_Z(POS_Z), .POS_Y(POS_Y), .POS_H(POS_H),
      .POS_X(POS_X), .POS_P(POS_P), .POS_N(POS_N), .POS_C(POS_C)
   ) u_flags (
      .mode_i  (fmode),
      .flags_i (flags_i),
      .val_i   (fval),
      .cout_i  (fcout),
      .bzero_i (bit_zero),
      .flags_o (flags_o)
   );
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk
   import rsb_pkg::*;
#(
   parameter int W      = 8,
   parameter int IDX_W  = 3,
   parameter int POS_S  = 7,
   parameter int POS_Z  = 6,
   parameter int POS_H  = 4,
   parameter int POS_P  = 2,
   parameter int POS_N  = 1,
   parameter int POS_C  = 0
) (
   input logic [W-1:0]     opnd_i,
   input logic [W-1:0]     acc_i,
   input logic [7:0]       flags_i,
   input logic [IDX_W-1:0] bit_sel_i,
   input logic [OP_W-1:0]  op_i,
   input logic [W-1:0]     result_o,
   input logic [W-1:0]     acc_o,
   input logic [7:0]       flags_o
);
   localparam int HALF = W / 2;

   always_comb begin
      if (op_i == OP_BCLR || op_i > OP_NRR) begin
         if (op_i != OP_BCLR) begin
            assert_unused_passthrough_R1: assert (result_o == opnd_i && acc_o == acc_i && flags_o == flags_i)
               else $error("unused code altered outputs");
         end
      end
      if (op_i == OP_RLC) begin
         assert_circular_wrap_R2: assert (result_o[0] == opnd_i[W-1] && flags_o[POS_C] == opnd_i[W-1])
            else $error("circular rotate lost the wrapped bit");
      end
      if (op_i <= OP_SRL) begin
         assert_shift_flags_R5: assert (flags_o[POS_Z] == (result_o == '0) && !flags_o[POS_H]
                                        && !flags_o[POS_N] && acc_o == acc_i)
            else $error("shift flags inconsistent with result");
      end
      if (op_i == OP_BTST) begin
         assert_bit_test_R6: assert (flags_o[POS_Z] == !opnd_i[bit_sel_i] && flags_o[POS_H]
                                     && result_o == opnd_i)
            else $error("bit test flag wrong");
      end
      if (op_i == OP_BCLR || op_i == OP_BSET) begin
         assert_bitop_flags_R7: assert (flags_o == flags_i)
            else $error("bit clear/set touched flags");
      end
      if (op_i >= OP_ARLC && op_i <= OP_ARR) begin
         assert_fast_keep_R8: assert (flags_o[POS_S] == flags_i[POS_S] && flags_o[POS_Z] == flags_i[POS_Z]
                                      && flags_o[POS_P] == flags_i[POS_P] && result_o == opnd_i)
            else $error("fast rotate changed kept flags");
      end
      if (op_i == OP_NRL || op_i == OP_NRR) begin
         assert_nibble_keep_R11: assert (acc_o[W-1:HALF] == acc_i[W-1:HALF] && flags_o[POS_C] == flags_i[POS_C])
            else $error("nibble rotate changed kept state");
      end
   end
endmodule

bind rsb_unit rsb_unit_chk #(
   .W(W), .IDX_W(IDX_W),
   .POS_S(POS_S), .POS_Z(POS_Z), .POS_H(POS_H),
   .POS_P(POS_P), .POS_N(POS_N), .POS_C(POS_C)
) u_chk (
   .opnd_i    (opnd_i),
   .acc_i     (acc_i),
   .flags_i   (flags_i),
   .bit_sel_i (bit_sel_i),
   .op_i      (op_i),
   .result_o  (result_o),
   .acc_o     (acc_o),
   .flags_o   (flags_o)
);

// File: tb/rsb_unit_tb.sv
`timescale 1ns/1ps
module rsb_unit_tb;

   logic       clk;
   logic       rst_n;
   logic [7:0] opnd, acc, flg;
   logic [2:0] bsel;
   logic [4:0] op;
   logic [7:0] res_o, acc_o, flg_o;
   int         n_cmp;
   int         n_bad;
   bit         done;

   rsb_unit u_dut (
      .opnd_i    (opnd),
      .acc_i     (acc),
      .flags_i   (flg),
      .bit_sel_i (bsel),
      .op_i      (op),
      .result_o  (res_o),
      .acc_o     (acc_o),
      .flags_o   (flg_o)
   );

   initial begin
      clk = 1'b0;
      forever #2 clk = ~clk;
   end

   // flag byte: S Z y H x P N C from bit 7 down
   function automatic logic [7:0] full_flags(input logic [7:0] v, input logic c);
      logic [7:0] f;
      f = 8'h00;
      if (v >= 8'h80)                 f = f | 8'h80;
      if (v == 8'h00)                 f = f | 8'h40;
      f = f | (v & 8'h28);
      if (($countones(v) % 2) == 0)   f = f | 8'h04;
      if (c)                          f = f | 8'h01;
      return f;
   endfunction

   // kind 0..7 as in codes 0..7
   function automatic logic [7:0] rot_ref(input int kind, input logic [7:0] d,
                                          input logic cin, output logic co);
      int x;
      int v;
      x = int'(d);
      if (kind % 2 == 0) co = (x >= 128);
      else               co = (x % 2 == 1);
      case (kind)
         0: v = (x * 2) % 256 + (co ? 1 : 0);
         1: v = x / 2 + (co ? 128 : 0);
         2: v = (x * 2) % 256 + (cin ? 1 : 0);
         3: v = x / 2 + (cin ? 128 : 0);
         4: v = (x * 2) % 256;
         5: v = x / 2 + ((x >= 128) ? 128 : 0);
         6: v = (x * 2) % 256 + 1;
         default: v = x / 2;
      endcase
      return 8'(v);
   endfunction

   function automatic void ref_calc(input logic [4:0] o, input logic [7:0] d, a, f,
                                    input logic [2:0] idx,
                                    output logic [7:0] r, an, fn);
      logic co;
      logic [7:0] v;
      int x, y;
      r  = d;
      an = a;
      fn = f;
      x  = int'(d);
      y  = int'(a);
      if (o <= 5'd7) begin
         v  = rot_ref(int'(o), d, f[0], co);
         r  = v;
         fn = full_flags(v, co);
      end else if (o == 5'd8) begin
         fn = (f & 8'hAD) | 8'h10 | (((x >> idx) % 2 == 0) ? 8'h40 : 8'h00);
      end else if (o == 5'd9) begin
         r = d & ~(8'(1 << idx));
      end else if (o == 5'd10) begin
         r = d | 8'(1 << idx);
      end else if (o >= 5'd12 && o <= 5'd15) begin
         v  = rot_ref(int'(o) - 12, a, f[0], co);
         an = v;
         fn = (f & 8'hC4) | (v & 8'h28) | (co ? 8'h01 : 8'h00);
      end else if (o == 5'd16) begin
         r  = 8'((x % 16) * 16 + y % 16);
         an = 8'((y / 16) * 16 + x / 16);
         fn = full_flags(an, f[0]);
      end else if (o == 5'd17) begin
         r  = 8'((y % 16) * 16 + x / 16);
         an = 8'((y / 16) * 16 + x % 16);
         fn = full_flags(an, f[0]);
      end
   endfunction

   function automatic string data_tag(input logic [4:0] o);
      if (o <= 5'd1)                return "R2";
      if (o <= 5'd3)                return "R3";
      if (o <= 5'd7)                return "R4";
      if (o == 5'd8)                return "R6";
      if (o == 5'd9 || o == 5'd10)  return "R7";
      if (o >= 5'd12 && o <= 5'd15) return "R8";
      if (o == 5'd16)               return "R9";
      if (o == 5'd17)               return "R10";
      return "R1";
   endfunction

   function automatic string flag_tag(input logic [4:0] o);
      if (o <= 5'd7)                return "R5";
      if (o == 5'd16 || o == 5'd17) return "R11";
      return data_tag(o);
   endfunction

   task automatic apply(input logic [4:0] o, input logic [7:0] d, a, f, input logic [2:0] idx);
      logic [7:0] er, ea, ef;
      @(posedge clk);
      op   = o;
      opnd = d;
      acc  = a;
      flg  = f;
      bsel = idx;
      ref_calc(o, d, a, f, idx, er, ea, ef);
      @(negedge clk);
      n_cmp++;
      if (res_o !== er || acc_o !== ea) begin
         n_bad++;
         $display("FAIL %s op=%0d d=%h a=%h f=%h idx=%0d: result/acc actual %h/%h expected %h/%h",
                  data_tag(o), o, d, a, f, idx, res_o, acc_o, er, ea);
      end
      n_cmp++;
      if (flg_o !== ef) begin
         n_bad++;
         $display("FAIL %s op=%0d d=%h a=%h f=%h idx=%0d: flags actual %h expected %h",
                  flag_tag(o), o, d, a, f, idx, flg_o, ef);
      end
   endtask

   initial begin
      done = 1'b0;
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R1: run did not finish, actual running expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   logic [7:0] pat [8];

   initial begin
      n_cmp = 0;
      n_bad = 0;
      rst_n = 1'b0;
      op = '0; opnd = '0; acc = '0; flg = '0; bsel = '0;
      pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'h80; pat[3] = 8'h01;
      pat[4] = 8'h0F; pat[5] = 8'hF0; pat[6] = 8'hA5; pat[7] = 8'h5A;
      repeat (3) @(posedge clk);
      // reset-time state: all-zero inputs, code 0 -> zero and parity set (R2, R5)
      apply(5'd0, 8'h00, 8'h00, 8'h00, 3'd0);
      rst_n = 1'b1;
      // directed sweep over every code, edge bytes and both carry values
      for (int o = 0; o < 32; o++) begin
         for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 2; c++) begin
               apply(5'(o), pat[p], pat[(p + 3) % 8], (c != 0) ? 8'h01 : 8'hFE, 3'(p));
            end
         end
      end
      // random operands, accumulators, flag bytes and bit indices
      for (int k = 0; k < 3000; k++) begin
         apply(5'($urandom_range(0, 31)), 8'($urandom), 8'($urandom), 8'($urandom),
               3'($urandom_range(0, 7)));
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule